// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of an 8-bit asynchronous NOR flash bus. A client hands it one request (an operation code, a target address and a data byte) with a single-cycle start pulse. The block turns that request into the unlock-and-command write cycles the flash expects, shaping each write-enable pulse with clock-cycle counters. It then polls the flash with read cycles until the operation completes or a timeout expires, and answers with a one-cycle done pulse and an error flag.

Three operations are supported: byte program, sector erase and chip erase. For each write cycle the block drives the address, the write data and a data-pad output enable. Chip enable stays low for the whole cycle, output enable stays high, and write enable pulses low. Completion is detected by complement polling on data bit 7. When bit 7 matches, one confirming read compares the whole byte before the block reports.

The controller is one state machine. Its states are IDLE, WSET (address and data set up, strobe high), WLOW (strobe low), WHIGH (strobe high, data held), PREAD (poll read), PGAP (output enable high between polls), VREAD (confirming read) and FIN (done pulse). Its transitions are:

- IDLE→WSET on a start with a legal code, and IDLE→FIN on the reserved code.
- WSET→WLOW→WHIGH, each when its phase timer expires.
- WHIGH→WSET to the next command cycle, or WHIGH→PREAD after the last one.
- PREAD→VREAD when bit 7 matches, PREAD→PGAP when it does not, and PGAP→PREAD when the gap ends.
- PREAD or PGAP→FIN on timeout.
- VREAD→FIN, then FIN→IDLE.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is held and after it is released, the bus is idle and `req_done` is 0. Idle means `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1 and `fl_drive` is 0.
- R2: Operation code 2'b00 (byte program) produces exactly four write cycles: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then `req_data` to `req_addr`.
- R3: Operation code 2'b01 (sector erase) and 2'b10 (chip erase) produce exactly six write cycles. The first five are 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555 and 0x55 to 0x2AAA. The sixth is 0x30 to `req_addr` for sector erase, or 0x10 to 0x5555 for chip erase.
- R4: Each write-enable low pulse lasts at least ceil(WE_LOW_NS/CLK_NS) cycles. Write enable stays high for at least ceil(WE_HIGH_NS/CLK_NS) cycles between pulses. Address and write data are stable for the whole low pulse.
- R5: Whenever write enable is low, chip enable is low, output enable is high and the data pads are driven.
- R6: After the last write the block issues reads at `req_addr` (output enable low, write enable high, pads not driven). It repeats them with output enable returned high between reads, until read bit 7 equals bit 7 of the expected byte. The expected byte is `req_data` for a program and 0xFF for an erase.
- R7: Once bit 7 matches, one further read is taken. `req_done` then rises with `req_error` = 0 if that byte equals the expected byte, and `req_error` = 1 otherwise.
- R8: If polling lasts ceil(PROG_TOUT_NS/CLK_NS) cycles for a program, or ceil(ERASE_TOUT_NS/CLK_NS) cycles for an erase, the block stops. It returns the bus to idle and pulses `req_done` with `req_error` = 1.
- R9: `req_done` is high for exactly one cycle per accepted request, and `req_error` holds its value until the next accepted start.
- R10: Operation code 2'b11 is reserved. It issues no bus cycle and yields `req_done` with `req_error` = 1 one cycle after the start.
- R11: A start pulse while a request is in progress is ignored. The running operation and its command cycles are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request strobe, taken in IDLE only |
| req_op | input | 2 | Operation code: 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| req_addr | input | ADDR_W | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| req_done | output | 1 | One-cycle completion pulse |
| req_error | output | 1 | Failure flag of the last request |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_wdata | output | 8 | Flash write data |
| fl_drive | output | 1 | Data pad output enable |
| fl_rdata | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
The assertions assume that `fl_rdata` is stable and valid at each clock edge while output enable is low. They also assume that start pulses are only one cycle wide and that reset is applied before the first edge. The bench's flash model meets these assumptions: it runs on the falling clock edge, returns read data combinationally from its own busy counter, and answers with complemented bit 7 and a toggling bit 6 while busy. The bench drives every request input on the falling edge and holds `req_start` high for a single cycle, so the sequencer never samples a changing input.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_RSVD = 2'b11
    } fop_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WSET,
        S_WLOW,
        S_WHIGH,
        S_PREAD,
        S_PGAP,
        S_VREAD,
        S_FIN
    } fsq_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam logic [7:0] KEY_A       = 8'hAA;
    localparam logic [7:0] KEY_B       = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECT    = 8'h30;
    localparam logic [15:0] UNLOCK_HI  = 16'h5555;
    localparam logic [15:0] UNLOCK_LO  = 16'h2AAA;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic longint unsigned ns2cyc(input longint unsigned ns,
                                               input longint unsigned per);
        longint unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/flash_cmd_gen.sv
// Address and data of command cycle `step` for the selected operation.
module flash_cmd_gen
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 17
)(
    input  fop_e              op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [7:0]        cyc_data,
    output logic              cyc_last
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(UNLOCK_HI);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(UNLOCK_LO);

    logic is_prog;
    assign is_prog  = (op == OP_PROG);
    assign cyc_last = is_prog ? (step == 3'd3) : (step == 3'd5);

    always_comb begin
        cyc_addr = A_HI;
        cyc_data = KEY_A;
        unique case (step)
            3'd0: begin cyc_addr = A_HI; cyc_data = KEY_A; end
            3'd1: begin cyc_addr = A_LO; cyc_data = KEY_B; end
            3'd2: begin cyc_addr = A_HI; cyc_data = is_prog ? CMD_PROG : CMD_ERASE; end
            3'd3: begin
                cyc_addr = is_prog ? tgt_addr : A_HI;
                cyc_data = is_prog ? tgt_data : KEY_A;
            end
            3'd4: begin cyc_addr = A_LO; cyc_data = KEY_B; end
            3'd5: begin
                cyc_addr = (op == OP_CHIP) ? A_HI : tgt_addr;
                cyc_data = (op == OP_CHIP) ? CMD_CHIP : CMD_SECT;
            end
            default: begin cyc_addr = A_HI; cyc_data = KEY_A; end
        endcase
    end
endmodule

// File: rtl/flash_phase_tmr.sv
// Down-counter: loaded with a phase length, reports its final cycle.
module flash_phase_tmr #(
    parameter int W = 8
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len - W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/flash_tout_ctr.sv
// Counts polling cycles; flags when the limit is reached.
module flash_tout_ctr #(
    parameter int W = 16
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (run && cnt_q != {W{1'b1}})
            cnt_q <= cnt_q + W'(1);
    end

    assign hit = run && (cnt_q >= limit - W'(1));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int              ADDR_W        = 17,
    parameter longint unsigned CLK_NS        = 8,
    parameter longint unsigned WE_LOW_NS     = 90,
    parameter longint unsigned WE_HIGH_NS    = 90,
    parameter longint unsigned RD_ACC_NS     = 70,
    parameter longint unsigned OE_GAP_NS     = 20,
    parameter longint unsigned PROG_TOUT_NS  = 64'd50_000,
    parameter longint unsigned ERASE_TOUT_NS = 64'd10_000_000_000
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              req_done,
    output logic              req_error,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_drive,
    input  logic [7:0]        fl_rdata,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n
);
    localparam longint unsigned WLO_CYC = ns2cyc(WE_LOW_NS, CLK_NS);
    localparam longint unsigned WHI_CYC = ns2cyc(WE_HIGH_NS, CLK_NS);
    localparam longint unsigned RD_CYC  = ns2cyc(RD_ACC_NS, CLK_NS);
    localparam longint unsigned GAP_CYC = ns2cyc(OE_GAP_NS, CLK_NS);
    localparam longint unsigned PTO_CYC = ns2cyc(PROG_TOUT_NS, CLK_NS);
    localparam longint unsigned ETO_CYC = ns2cyc(ERASE_TOUT_NS, CLK_NS);
    localparam longint unsigned PH_MAX1 = (WLO_CYC > WHI_CYC) ? WLO_CYC : WHI_CYC;
    localparam longint unsigned PH_MAX2 = (RD_CYC > GAP_CYC) ? RD_CYC : GAP_CYC;
    localparam longint unsigned PH_MAX  = (PH_MAX1 > PH_MAX2) ? PH_MAX1 : PH_MAX2;
    localparam longint unsigned TO_MAX  = (PTO_CYC > ETO_CYC) ? PTO_CYC : ETO_CYC;
    localparam int PH_W = $clog2(PH_MAX + 1) + 1;
    localparam int TO_W = $clog2(TO_MAX + 1) + 1;

    fsq_e              state_q, state_d;
    fop_e              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q, exp_q;
    logic [2:0]        step_q, step_d;
    logic              err_q, err_d;
    logic              capture;

    logic [ADDR_W-1:0] cyc_addr;
    logic [7:0]        cyc_data;
    logic              cyc_last;
    logic              ph_load, ph_last;
    logic [PH_W-1:0]   ph_len;
    logic              to_run, to_clear, to_hit;
    logic [TO_W-1:0]   to_limit;

    flash_cmd_gen #(.ADDR_W(ADDR_W)) u_cmd (
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .cyc_addr (cyc_addr),
        .cyc_data (cyc_data),
        .cyc_last (cyc_last)
    );

    flash_phase_tmr #(.W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ph_load),
        .len   (ph_len),
        .last  (ph_last)
    );

    flash_tout_ctr #(.W(TO_W)) u_tout (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (to_clear),
        .run   (to_run),
        .limit (to_limit),
        .hit   (to_hit)
    );

    assign capture  = (state_q == S_IDLE) && req_start;
    assign to_run   = (state_q == S_PREAD) || (state_q == S_PGAP);
    assign to_clear = (state_q == S_IDLE);
    assign to_limit = (op_q == OP_PROG) ? TO_W'(PTO_CYC) : TO_W'(ETO_CYC);
    assign ph_load  = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            S_WLOW:           ph_len = PH_W'(WLO_CYC);
            S_WHIGH:          ph_len = PH_W'(WHI_CYC);
            S_PREAD, S_VREAD: ph_len = PH_W'(RD_CYC);
            S_PGAP:           ph_len = PH_W'(GAP_CYC);
            default:          ph_len = PH_W'(1);
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        err_d   = err_q;
        unique case (state_q)
            S_IDLE: if (req_start) begin
                step_d = 3'd0;
                if (fop_e'(req_op) == OP_RSVD) begin
                    state_d = S_FIN;
                    err_d   = 1'b1;
                end else begin
                    state_d = S_WSET;
                    err_d   = 1'b0;
                end
            end
            S_WSET:  if (ph_last) state_d = S_WLOW;
            S_WLOW:  if (ph_last) state_d = S_WHIGH;
            S_WHIGH: if (ph_last) begin
                if (cyc_last) begin
                    state_d = S_PREAD;
                end else begin
                    state_d = S_WSET;
                    step_d  = step_q + 3'd1;
                end
            end
            S_PREAD: begin
                if (ph_last && (fl_rdata[7] == exp_q[7])) begin
                    state_d = S_VREAD;
                end else if (to_hit) begin
                    state_d = S_FIN;
                    err_d   = 1'b1;
                end else if (ph_last) begin
                    state_d = S_PGAP;
                end
            end
            S_PGAP: begin
                if (to_hit) begin
                    state_d = S_FIN;
                    err_d   = 1'b1;
                end else if (ph_last) begin
                    state_d = S_PREAD;
                end
            end
            S_VREAD: if (ph_last) begin
                state_d = S_FIN;
                err_d   = (fl_rdata != exp_q);
            end
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= 3'd0;
            err_q   <= 1'b0;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= 8'h00;
            exp_q   <= 8'h00;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            err_q   <= err_d;
            if (capture) begin
                op_q   <= fop_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
                exp_q  <= (fop_e'(req_op) == OP_PROG) ? req_data : ERASED_BYTE;
            end
        end
    end

    // Outputs
    always_comb begin
        fl_ce_n   = 1'b1;
        fl_oe_n   = 1'b1;
        fl_we_n   = 1'b1;
        fl_drive  = 1'b0;
        fl_addr   = '0;
        fl_wdata  = 8'h00;
        req_done  = 1'b0;
        req_error = err_q;
        unique case (state_q)
            S_WSET, S_WHIGH: begin
                fl_ce_n  = 1'b0;
                fl_drive = 1'b1;
                fl_addr  = cyc_addr;
                fl_wdata = cyc_data;
            end
            S_WLOW: begin
                fl_ce_n  = 1'b0;
                fl_we_n  = 1'b0;
                fl_drive = 1'b1;
                fl_addr  = cyc_addr;
                fl_wdata = cyc_data;
            end
            S_PREAD, S_VREAD: begin
                fl_ce_n = 1'b0;
                fl_oe_n = 1'b0;
                fl_addr = addr_q;
            end
            S_PGAP: begin
                fl_ce_n = 1'b0;
                fl_addr = addr_q;
            end
            S_FIN:   req_done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk
    import flash_seq_pkg::*;
#(
    parameter int              ADDR_W    = 17,
    parameter longint unsigned CLK_NS    = 8,
    parameter longint unsigned WE_LOW_NS = 90
)(
    input logic              clk,
    input logic              rst_n,
    input logic              req_done,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_wdata,
    input logic              fl_drive,
    input logic              fl_ce_n,
    input logic              fl_oe_n,
    input logic              fl_we_n
);
    localparam longint unsigned WLO_MIN = ns2cyc(WE_LOW_NS, CLK_NS);

    logic [31:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             low_run <= '0;
        else if (!fl_we_n)      low_run <= low_run + 32'd1;
        else                    low_run <= '0;
    end

    a_r5_strobe_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_drive));

    a_r4_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

    a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (64'(low_run) >= WLO_MIN));

    a_r6_read_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_drive && fl_we_n && !fl_ce_n));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_drive));
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .ADDR_W    (ADDR_W),
    .CLK_NS    (CLK_NS),
    .WE_LOW_NS (WE_LOW_NS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_done (req_done),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_drive (fl_drive),
    .fl_ce_n  (fl_ce_n),
    .fl_oe_n  (fl_oe_n),
    .fl_we_n  (fl_we_n)
);

// File: tb/flash_prog_seq_tb.sv
`timescale 1ns/1ps
module flash_prog_seq_tb;
    localparam int AW      = 17;
    localparam int WMIN    = 12;   // ceil(90/8)
    localparam int PTO     = 500;  // 4000 ns / 8 ns
    localparam int ETO     = 1000; // 8000 ns / 8 ns

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    always #4 clk = ~clk;

    logic          req_start = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          req_done, req_error;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata, fl_rdata;
    logic          fl_drive, fl_ce_n, fl_oe_n, fl_we_n;

    flash_prog_seq #(
        .ADDR_W(AW), .CLK_NS(8), .WE_LOW_NS(90), .WE_HIGH_NS(90),
        .RD_ACC_NS(70), .OE_GAP_NS(20),
        .PROG_TOUT_NS(64'd4000), .ERASE_TOUT_NS(64'd8000)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_done(req_done),
        .req_error(req_error), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_drive(fl_drive), .fl_rdata(fl_rdata), .fl_ce_n(fl_ce_n),
        .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    // ---------------- flash model (falling edge) ----------------
    logic          mdl_clr = 1'b0;
    logic [15:0]   mdl_busy = 16'd0;
    logic [7:0]    mdl_final = 8'h00;
    logic [AW-1:0] log_addr [0:7];
    logic [7:0]    log_data [0:7];
    int            log_n = 0;
    int            viol = 0;
    int            lo_cnt = 0, hi_cnt = 0;
    logic          we_prev = 1'b1, oe_prev = 1'b1, tog = 1'b0;
    logic [AW-1:0] cap_addr = '0;
    logic [15:0]   busy_cnt = 16'd0;
    logic [7:0]    fin_v = 8'h00;

    assign fl_rdata = (!fl_ce_n && !fl_oe_n)
                    ? ((busy_cnt != 0) ? {~fin_v[7], tog, fin_v[5:0]} : fin_v)
                    : 8'h00;

    always @(negedge clk) begin
        if (mdl_clr) begin
            log_n <= 0; viol <= 0; lo_cnt <= 0; hi_cnt <= 0;
            busy_cnt <= 16'd0; we_prev <= 1'b1; oe_prev <= 1'b1;
        end else begin
            we_prev <= fl_we_n;
            oe_prev <= fl_oe_n;
            if (!fl_oe_n && oe_prev) tog <= ~tog;
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 16'd1;
            if (!fl_we_n) begin
                lo_cnt <= lo_cnt + 1;
                if (fl_ce_n || !fl_oe_n || !fl_drive) viol <= viol + 1;   // R5
                if (we_prev) begin
                    cap_addr <= fl_addr;
                    if (log_n != 0 && hi_cnt < WMIN) viol <= viol + 1;    // R4 high
                end
            end else begin
                hi_cnt <= hi_cnt + 1;
                if (!we_prev) begin
                    if (lo_cnt < WMIN) viol <= viol + 1;                  // R4 low
                    if (log_n < 8) begin
                        log_addr[log_n] <= cap_addr;
                        log_data[log_n] <= fl_wdata;
                    end
                    log_n  <= log_n + 1;
                    hi_cnt <= 1;
                    lo_cnt <= 0;
                    if ((log_n == 3 && log_data[2] == 8'hA0) || log_n == 5) begin
                        busy_cnt <= mdl_busy;
                        fin_v    <= mdl_final;
                    end
                end
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW+7:0] exp_wr(input logic [1:0] op, input logic [AW-1:0] a,
                                             input logic [7:0] d, input int k);
        logic [AW-1:0] hi, lo;
        hi = AW'(17'h05555);
        lo = AW'(17'h02AAA);
        case (k)
            0: return {hi, 8'hAA};
            1: return {lo, 8'h55};
            2: return (op == 2'b00) ? {hi, 8'hA0} : {hi, 8'h80};
            3: return (op == 2'b00) ? {a, d} : {hi, 8'hAA};
            4: return {lo, 8'h55};
            default: return (op == 2'b10) ? {hi, 8'h10} : {a, 8'h30};
        endcase
    endfunction

    int  elapsed;
    bit  got_err, got_done, after_done;

    task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic [15:0] busy, input logic [7:0] fv, input bit interfere);
        mdl_busy = busy; mdl_final = fv;
        @(negedge clk); mdl_clr = 1'b1;
        repeat (2) @(negedge clk);
        mdl_clr = 1'b0;
        req_op = op; req_addr = a; req_data = d; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        elapsed = 1;
        while (!req_done && elapsed < 20000) begin
            if (interfere && elapsed == 30) begin
                req_op = 2'b10; req_addr = '0; req_data = 8'h5A; req_start = 1'b1;
            end else begin
                req_start = 1'b0;
            end
            @(negedge clk);
            elapsed++;
        end
        req_start = 1'b0;
        got_done = req_done;
        got_err  = req_error;
        @(negedge clk);
        after_done = req_done;
    endtask

    task automatic check_seq(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                             input string tag);
        int  len;
        bit  ok;
        len = (op == 2'b00) ? 4 : 6;
        chk(log_n == len, tag, log_n, len);
        ok = 1'b1;
        for (int k = 0; k < len && k < 8; k++)
            if ({log_addr[k], log_data[k]} != exp_wr(op, a, d, k)) ok = 1'b0;
        chk(ok, tag, log_n, len);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [15:0]   busy;
        logic [7:0]    fin;
        logic          err;
        logic [3:0]    tag;   // requirement checked for the outcome
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 17'h01234, 8'h3C, 16'd100,   8'h3C, 1'b0, 4'd6}, // R6 program, bit7 0
        '{2'b00, 17'h1FFFF, 8'hA5, 16'd40,    8'hA5, 1'b0, 4'd6}, // R6 program, bit7 1
        '{2'b01, 17'h08000, 8'h00, 16'd200,   8'hFF, 1'b0, 4'd3}, // R3 sector erase
        '{2'b10, 17'h00000, 8'h00, 16'd300,   8'hFF, 1'b0, 4'd3}, // R3 chip erase
        '{2'b00, 17'h00010, 8'h81, 16'd50,    8'h80, 1'b1, 4'd7}, // R7 bit7 ok, byte wrong
        '{2'b00, 17'h00020, 8'h00, 16'd0,     8'h00, 1'b0, 4'd7}, // R7 ready at first poll
        '{2'b01, 17'h10000, 8'h00, 16'd65000, 8'hFF, 1'b1, 4'd8}, // R8 erase timeout
        '{2'b00, 17'h00040, 8'h7E, 16'd2000,  8'h7E, 1'b1, 4'd8}  // R8 program timeout
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        string t;
        #2 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: idle bus during reset
        chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_drive && !req_done, "R1",
            {fl_ce_n, fl_oe_n, fl_we_n, fl_drive, req_done}, 5'b11100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_drive && !req_done, "R1",
            {fl_ce_n, fl_oe_n, fl_we_n, fl_drive, req_done}, 5'b11100);

        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].busy, VECS[i].fin, 1'b0);
            t = $sformatf("R%0d vec%0d", VECS[i].tag, i);
            chk(got_done, t, got_done, 1);
            chk(got_err == VECS[i].err, t, got_err, VECS[i].err);
            check_seq(VECS[i].op, VECS[i].addr, VECS[i].data,
                      (VECS[i].op == 2'b00) ? "R2 sequence" : "R3 sequence");
            chk(viol == 0, "R4/R5 strobe timing", viol, 0);
            chk(!after_done, "R9 done pulse", after_done, 0);
            chk(req_error == VECS[i].err, "R9 error held", req_error, VECS[i].err);
            if (VECS[i].tag == 4'd8) begin
                int lim;
                lim = (VECS[i].op == 2'b00) ? PTO : ETO;
                chk(elapsed >= lim && elapsed <= lim + 200, "R8 timeout window", elapsed, lim);
            end
        end

        // R10: reserved code
        do_op(2'b11, 17'h00100, 8'h11, 16'd0, 8'h00, 1'b0);
        chk(got_done && got_err, "R10 reserved error", {got_done, got_err}, 2'b11);
        chk(elapsed <= 2, "R10 latency", elapsed, 2);
        chk(log_n == 0, "R10 no writes", log_n, 0);

        // R11: start while busy is ignored
        do_op(2'b00, 17'h00200, 8'h42, 16'd60, 8'h42, 1'b1);
        chk(got_done && !got_err, "R11 first op completes", {got_done, got_err}, 2'b10);
        check_seq(2'b00, 17'h00200, 8'h42, "R11 sequence");
        repeat (5) @(negedge clk);
        chk(!req_done && fl_ce_n, "R11 no second op", {req_done, fl_ce_n}, 2'b01);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule